// File: doc/BRIEF.md
# Continuous Audio Bit-Stream DMA Engine

This block moves a one-bit serial audio stream between the pins and two word buffers in memory, without stopping. One buffer takes recorded bits and the other supplies playback bits. Both buffers share a single length, written in eight-byte units. An internal divider turns the system clock into a bit strobe at one of three selectable rates. On every strobe the engine samples one input bit, emits one output bit and decrements a bit countdown. Input bits are packed MSB-first into 32-bit words, and each full word is written to the record buffer. Each playback word is fetched when its first bit is due. When the countdown expires, the countdown reloads and both buffer offsets return to zero, so the buffers are used as rings.

Software sets the engine up through a small register window at byte offsets 0x200 to 0x2FF. The window repeats every 32 bytes. The window holds a control word, two buffer base addresses, the shared length and a readable countdown. An optional pass-through mode copies every recorded word into the playback buffer as well. Writing a control word with both transfer enables clear stops the engine and rewinds it to the buffer start.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset, every register reads zero, no request or bit strobe is active and `ser_o` is 0.
- R2: The window decodes `reg_addr_i[4:0]` when `reg_addr_i[11:8]` is 2. Offset 0x00 is the control word in data bits 15:0, and a write to 0x02 also updates it. 0x0E reads the bit countdown and ignores writes. 0x10 is the record base, 0x14 the playback base and 0x18 the length in bits 15:0. Any other offset reads 0.
- R3: The window repeats every 32 bytes from 0x200 up to 0x2FF. An access outside that range neither changes state nor returns data.
- R4: Control bits 10:9 set the bit rate. 00 gives one strobe every DIV_SLOW clocks, 01 every DIV_MID clocks, and 10 or 11 every DIV_FAST clocks. `bit_tick_o` marks each strobe.
- R5: A length write loads the countdown with length×64, modulo 2^16, and clears the position. Each strobe lowers the countdown by one. A strobe that finds it at 1 reloads length×64 and returns the word offset to 0.
- R6: Control bit 7 enables recording. `ser_i` is taken on each strobe, MSB first. The cycle after the 32nd bit of a word, `in_wr_req_o` pulses with address record base + 4×word offset and the packed data.
- R7: Control bit 8 enables playback. On the strobe of bit 0 of each word, `rd_req_o` is high with address playback base + 4×word offset, and `rd_data_i` is taken in that cycle. Its bits appear MSB first on `ser_o`, each from the cycle after its strobe. While playback is off, the bit shifted out is 0.
- R8: Control bit 2 gates the speaker. When it is 0, `ser_o` is 0.
- R9: With control bit 6 and bit 7 both set, each recorded word is also written, in the same cycle, to playback base + 4×word offset through `mirror_wr_req_o`.
- R10: While control bits 8:7 are both 0, there are no strobes and no requests. A control write with both bits clear rewinds the engine: countdown to length×64, offset 0, partial word dropped.
- R11: A countdown of zero keeps the engine idle even when it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| ser_i | input | 1 | Serial record bit |
| ser_o | output | 1 | Serial playback bit |
| bit_tick_o | output | 1 | Bit strobe |
| rd_req_o | output | 1 | Playback word fetch |
| rd_addr_o | output | 32 | Playback fetch address |
| rd_data_i | input | 32 | Fetched word, valid in the request cycle |
| in_wr_req_o | output | 1 | Record word write |
| in_wr_addr_o | output | 32 | Record write address |
| wr_data_o | output | 32 | Packed word for both writes |
| mirror_wr_req_o | output | 1 | Pass-through copy write |
| mirror_wr_addr_o | output | 32 | Pass-through copy address |

## Verification
Several properties are checked on every cycle:
- a fetch happens only on a strobe;
- record-write pulses are never back to back;
- a mirror write never occurs without a record write;
- an engine with both transfers off stays silent;
- a zero countdown stays idle;
- the countdown steps down by exactly one per strobe and holds between strobes.

Only the bench scenarios can show the rest: the decoded register map and its aliases, the exact rate spacing, MSB-first packing, the address sequence, the ring wrap, and muting. The bench shows these by comparing against a queue-based model over several control settings.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam logic [3:0] WIN_PAGE   = 4'h2;
  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_CTRL2  = 5'h02;
  localparam logic [4:0] OFS_BITS   = 5'h0E;
  localparam logic [4:0] OFS_INBASE = 5'h10;
  localparam logic [4:0] OFS_OUTBASE= 5'h14;
  localparam logic [4:0] OFS_LEN    = 5'h18;

  typedef struct packed {
    logic       out_en;
    logic       in_en;
    logic       pass;
    logic       spk;
    logic [1:0] rate;
  } ctl_t;

  function automatic ctl_t ctl_decode(logic [15:0] c);
    ctl_t r;
    r.out_en = c[8];
    r.in_en  = c[7];
    r.pass   = c[6];
    r.spk    = c[2];
    r.rate   = c[10:9];
    return r;
  endfunction
endpackage

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] bits_left_i,
  output logic [31:0]      rdata_o,
  output logic [15:0]      ctrl_o,
  output logic [AW-1:0]    in_base_o,
  output logic [AW-1:0]    out_base_o,
  output logic [CNT_W-1:0] len_o,
  output logic             rewind_o,
  output logic [CNT_W-1:0] rewind_len_o
);
  logic       in_win;
  logic [4:0] ofs;
  logic       wr_ctrl, wr_len;

  assign in_win  = (addr_i[11:8] == WIN_PAGE);
  assign ofs     = addr_i[4:0];
  assign wr_ctrl = wr_i && in_win && (ofs == OFS_CTRL || ofs == OFS_CTRL2);
  assign wr_len  = wr_i && in_win && (ofs == OFS_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      in_base_o  <= '0;
      out_base_o <= '0;
      len_o      <= '0;
    end else if (wr_i && in_win) begin
      if (wr_ctrl) ctrl_o <= wdata_i[15:0];
      if (ofs == OFS_INBASE)  in_base_o  <= wdata_i[AW-1:0];
      if (ofs == OFS_OUTBASE) out_base_o <= wdata_i[AW-1:0];
      if (wr_len) len_o <= wdata_i[CNT_W-1:0];
    end
  end

  // stop-write or length write restarts the stream at the buffer start
  assign rewind_o     = wr_len || (wr_ctrl && wdata_i[8:7] == 2'b00);
  assign rewind_len_o = wr_len ? wdata_i[CNT_W-1:0] : len_o;

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      unique case (ofs)
        OFS_CTRL, OFS_CTRL2: rdata_o = 32'(ctrl_o);
        OFS_BITS:            rdata_o = 32'(bits_left_i);
        OFS_INBASE:          rdata_o = 32'(in_base_o);
        OFS_OUTBASE:         rdata_o = 32'(out_base_o);
        OFS_LEN:             rdata_o = 32'(len_o);
        default:             rdata_o = '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr_i[7:5], wdata_i};
endmodule

// File: rtl/adma_rate_gen.sv
module adma_rate_gen #(
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_MID) ?
                                    ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                                    ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int unsigned DIV_W = $clog2(DIV_MAX) + 1;
  localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'(DIV_FAST - 1);
  localparam logic [DIV_W-1:0] LIM_MID  = DIV_W'(DIV_MID - 1);
  localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(DIV_SLOW - 1);

  logic [DIV_W-1:0] div_q, lim;

  always_comb begin
    unique case (rate_i)
      2'b00:   lim = LIM_SLOW;
      2'b01:   lim = LIM_MID;
      default: lim = LIM_FAST;
    endcase
  end

  // >= keeps a rate change from stranding the divider above the new limit
  assign tick_o = run_i && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/adma_stream.sv
module adma_stream
  import adma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  ctl_t             ctl_i,
  input  logic [AW-1:0]    in_base_i,
  input  logic [AW-1:0]    out_base_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             rewind_i,
  input  logic [CNT_W-1:0] rewind_len_i,
  input  logic             ser_i,
  input  logic [31:0]      rd_data_i,
  output logic [CNT_W-1:0] bits_left_o,
  output logic             run_o,
  output logic             ser_o,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             in_wr_req_o,
  output logic [AW-1:0]    in_wr_addr_o,
  output logic [31:0]      wr_data_o,
  output logic             mirror_wr_req_o,
  output logic [AW-1:0]    mirror_wr_addr_o
);
  localparam int unsigned WI_W = CNT_W - 5;

  logic [CNT_W-1:0] cnt_q, wrap_cnt, rew_cnt;
  logic [4:0]       bit_q;
  logic [WI_W-1:0]  word_q;
  logic [31:0]      in_sh_q, out_sh_q;
  logic             ser_q;
  logic             last_bit, word_end;
  logic [AW-1:0]    word_ofs;

  // length unit is 8 bytes = 64 bits
  assign wrap_cnt = {len_i[CNT_W-7:0], 6'b0};
  assign rew_cnt  = {rewind_len_i[CNT_W-7:0], 6'b0};
  assign last_bit = (cnt_q == CNT_W'(1));
  assign word_end = (bit_q == 5'd31);
  assign word_ofs = AW'({word_q, 2'b00});

  assign run_o       = (ctl_i.in_en || ctl_i.out_en) && (cnt_q != '0);
  assign bits_left_o = cnt_q;
  assign rd_req_o    = tick_i && ctl_i.out_en && (bit_q == 5'd0);
  assign rd_addr_o   = out_base_i + word_ofs;
  assign ser_o       = ser_q && ctl_i.spk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q            <= '0;
      bit_q            <= '0;
      word_q           <= '0;
      in_sh_q          <= '0;
      out_sh_q         <= '0;
      ser_q            <= 1'b0;
      in_wr_req_o      <= 1'b0;
      mirror_wr_req_o  <= 1'b0;
      in_wr_addr_o     <= '0;
      mirror_wr_addr_o <= '0;
      wr_data_o        <= '0;
    end else if (rewind_i) begin
      cnt_q           <= rew_cnt;
      bit_q           <= '0;
      word_q          <= '0;
      in_sh_q         <= '0;
      out_sh_q        <= '0;
      ser_q           <= 1'b0;
      in_wr_req_o     <= 1'b0;
      mirror_wr_req_o <= 1'b0;
    end else begin
      in_wr_req_o     <= 1'b0;
      mirror_wr_req_o <= 1'b0;
      if (tick_i) begin
        cnt_q   <= last_bit ? wrap_cnt : cnt_q - 1'b1;
        bit_q   <= bit_q + 1'b1;
        in_sh_q <= {in_sh_q[30:0], ser_i};
        if (word_end) word_q <= last_bit ? '0 : word_q + 1'b1;
        if (word_end && ctl_i.in_en) begin
          in_wr_req_o      <= 1'b1;
          mirror_wr_req_o  <= ctl_i.pass;
          wr_data_o        <= {in_sh_q[30:0], ser_i};
          in_wr_addr_o     <= in_base_i + word_ofs;
          mirror_wr_addr_o <= out_base_i + word_ofs;
        end
        if (ctl_i.out_en) begin
          if (bit_q == 5'd0) begin
            ser_q    <= rd_data_i[31];
            out_sh_q <= {rd_data_i[30:0], 1'b0};
          end else begin
            ser_q    <= out_sh_q[31];
            out_sh_q <= {out_sh_q[30:0], 1'b0};
          end
        end else begin
          ser_q <= 1'b0;
        end
      end
    end
  end

  logic unused_len;
  assign unused_len = ^{len_i[CNT_W-1:CNT_W-6], rewind_len_i[CNT_W-1:CNT_W-6]};
endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine
  import adma_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [11:0]   reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          ser_i,
  output logic          ser_o,
  output logic          bit_tick_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [31:0]   rd_data_i,
  output logic          in_wr_req_o,
  output logic [AW-1:0] in_wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic          mirror_wr_req_o,
  output logic [AW-1:0] mirror_wr_addr_o
);
  logic [15:0]      ctrl_q;
  logic [AW-1:0]    in_base, out_base;
  logic [CNT_W-1:0] len_q, bits_left, rewind_len;
  logic             rewind, run;
  ctl_t             ctl;

  assign ctl = ctl_decode(ctrl_q);

  adma_regs #(.AW(AW), .CNT_W(CNT_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .bits_left_i  (bits_left),
    .rdata_o      (reg_rdata_o),
    .ctrl_o       (ctrl_q),
    .in_base_o    (in_base),
    .out_base_o   (out_base),
    .len_o        (len_q),
    .rewind_o     (rewind),
    .rewind_len_o (rewind_len)
  );

  adma_rate_gen #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) i_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .rate_i (ctl.rate),
    .tick_o (bit_tick_o)
  );

  adma_stream #(.AW(AW), .CNT_W(CNT_W)) i_stream (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .tick_i           (bit_tick_o),
    .ctl_i            (ctl),
    .in_base_i        (in_base),
    .out_base_i       (out_base),
    .len_i            (len_q),
    .rewind_i         (rewind),
    .rewind_len_i     (rewind_len),
    .ser_i            (ser_i),
    .rd_data_i        (rd_data_i),
    .bits_left_o      (bits_left),
    .run_o            (run),
    .ser_o            (ser_o),
    .rd_req_o         (rd_req_o),
    .rd_addr_o        (rd_addr_o),
    .in_wr_req_o      (in_wr_req_o),
    .in_wr_addr_o     (in_wr_addr_o),
    .wr_data_o        (wr_data_o),
    .mirror_wr_req_o  (mirror_wr_req_o),
    .mirror_wr_addr_o (mirror_wr_addr_o)
  );
endmodule

// File: rtl/adma_checker.sv
module adma_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_o,
  input logic             rd_req_o,
  input logic             in_wr_req_o,
  input logic             mirror_wr_req_o,
  input logic [15:0]      ctrl_q,
  input logic [CNT_W-1:0] bits_left,
  input logic             rewind
);
  a_r7_fetch_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> bit_tick_o);

  a_r6_wr_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_wr_req_o |=> !in_wr_req_o);

  a_r9_mirror_with_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_wr_req_o |-> in_wr_req_o);

  a_r10_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[8:7] == 2'b00) |-> (!bit_tick_o && !rd_req_o));

  a_r11_zero_count_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_left == '0) |-> !bit_tick_o);

  a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && !rewind && bits_left > CNT_W'(1)) |=>
      (bits_left == $past(bits_left) - CNT_W'(1)));

  a_r5_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_o && !rewind) |=> $stable(bits_left));
endmodule

bind audio_dma_engine adma_checker #(.CNT_W(CNT_W)) i_adma_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bit_tick_o      (bit_tick_o),
  .rd_req_o        (rd_req_o),
  .in_wr_req_o     (in_wr_req_o),
  .mirror_wr_req_o (mirror_wr_req_o),
  .ctrl_q          (ctrl_q),
  .bits_left       (bits_left),
  .rewind          (rewind)
);

// File: tb/test_audio_dma_engine.sv
`timescale 1ns/1ps
module test_audio_dma_engine;
  localparam int DF = 4, DM = 8, DS = 9;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ser_i = 0, ser_o, bit_tick, rd_req, in_wr_req, mir_req;
  logic [31:0] rd_addr, rd_data, in_wr_addr, wr_data, mir_addr;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction
  assign rd_data = mem_word(rd_addr);

  audio_dma_engine #(.DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) i_audio_dma_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ser_i(ser_i), .ser_o(ser_o),
    .bit_tick_o(bit_tick), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .in_wr_req_o(in_wr_req), .in_wr_addr_o(in_wr_addr), .wr_data_o(wr_data),
    .mirror_wr_req_o(mir_req), .mirror_wr_addr_o(mir_addr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctrl, m_len;
  logic [31:0] m_in, m_out, m_wdata, m_waddr, m_maddr;
  int          m_cnt, m_div, m_bit, m_word;
  bit          m_ser, m_wreq, m_mreq;
  bit          q_in[$], q_out[$];

  function automatic int sel_div(logic [15:0] c);
    return c[10] ? DF : (c[9] ? DM : DS);
  endfunction
  function automatic bit m_tick();
    return (m_ctrl[8:7] != 0) && (m_cnt != 0) && (m_div >= sel_div(m_ctrl) - 1);
  endfunction
  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a[11:8] != 4'h2) return 0;
    case (a[4:0])
      5'h00, 5'h02: return {16'h0, m_ctrl};
      5'h0E:        return m_cnt;
      5'h10:        return m_in;
      5'h14:        return m_out;
      5'h18:        return {16'h0, m_len};
      default:      return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit run, tk, rw, last;
    logic [15:0] nctrl, nlen, rwlen;
    logic [31:0] nin, nout, w, d;
    if (!rst_n) begin
      m_ctrl = 0; m_len = 0; m_in = 0; m_out = 0; m_cnt = 0; m_div = 0;
      m_bit = 0; m_word = 0; m_ser = 0; m_wreq = 0; m_mreq = 0;
      m_wdata = 0; m_waddr = 0; m_maddr = 0; q_in.delete(); q_out.delete();
    end else begin
      run = (m_ctrl[8:7] != 0) && (m_cnt != 0);
      tk  = m_tick();
      m_div = (!run || tk) ? 0 : m_div + 1;
      nctrl = m_ctrl; nlen = m_len; nin = m_in; nout = m_out; rw = 0; rwlen = m_len;
      if (reg_wr && reg_addr[11:8] == 4'h2) begin
        case (reg_addr[4:0])
          5'h00, 5'h02: begin nctrl = reg_wdata[15:0]; if (reg_wdata[8:7] == 0) rw = 1; end
          5'h10: nin = reg_wdata;
          5'h14: nout = reg_wdata;
          5'h18: begin nlen = reg_wdata[15:0]; rw = 1; rwlen = reg_wdata[15:0]; end
          default: ;
        endcase
      end
      m_wreq = 0; m_mreq = 0;
      if (rw) begin
        m_cnt = (rwlen % 1024) * 64; m_bit = 0; m_word = 0; m_ser = 0;
        q_in.delete(); q_out.delete();
      end else if (tk) begin
        last = (m_cnt == 1);
        q_in.push_back(ser_i);
        if (q_in.size() > 32) void'(q_in.pop_front());
        if (m_bit == 31 && m_ctrl[7]) begin
          d = 0;
          foreach (q_in[i]) d = {d[30:0], q_in[i]};
          m_wreq = 1; m_mreq = m_ctrl[6]; m_wdata = d;
          m_waddr = m_in + 4 * m_word; m_maddr = m_out + 4 * m_word;
        end
        if (m_ctrl[8]) begin
          if (m_bit == 0) begin
            w = mem_word(m_out + 4 * m_word);
            m_ser = w[31];
            q_out.delete();
            for (int i = 30; i >= 0; i--) q_out.push_back(w[i]);
          end else m_ser = (q_out.size() > 0) ? q_out.pop_front() : 1'b0;
        end else m_ser = 0;
        if (m_bit == 31) m_word = last ? 0 : m_word + 1;
        m_cnt = last ? (m_len % 1024) * 64 : m_cnt - 1;
        m_bit = (m_bit + 1) % 32;
      end
      m_ctrl = nctrl; m_len = nlen; m_in = nin; m_out = nout;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit tk, rq;
    if (rst_n && !done) begin
      tk = m_tick();
      rq = tk && m_ctrl[8] && (m_bit == 0);
      chk(bit_tick === tk, "R4 bit_tick", 32'(bit_tick), 32'(tk));
      chk(rd_req === rq, "R7 rd_req", 32'(rd_req), 32'(rq));
      if (rq) chk(rd_addr === m_out + 4 * m_word, "R7 rd_addr", rd_addr, m_out + 4 * m_word);
      chk(in_wr_req === m_wreq, "R6 in_wr_req", 32'(in_wr_req), 32'(m_wreq));
      if (m_wreq) begin
        chk(in_wr_addr === m_waddr, "R6 in_wr_addr", in_wr_addr, m_waddr);
        chk(wr_data === m_wdata, "R6 wr_data", wr_data, m_wdata);
      end
      chk(mir_req === m_mreq, "R9 mirror_req", 32'(mir_req), 32'(m_mreq));
      if (m_mreq) chk(mir_addr === m_maddr, "R9 mirror_addr", mir_addr, m_maddr);
      chk(ser_o === (m_ser & m_ctrl[2]), "R7/R8 ser_o", 32'(ser_o), 32'(m_ser & m_ctrl[2]));
      chk(reg_rdata === m_read(reg_addr), "R2 rdata", reg_rdata, m_read(reg_addr));
    end
  end

  // serial source
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    #1;
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_i <= lfsr[0];
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    reg_addr = a; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic gap(input int exp, input string tag);
    int n;
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tick);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(12'h200, 0, "R1 ctrl after reset");
    rd(12'h20E, 0, "R1 countdown after reset");
    chk(ser_o === 0 && !bit_tick && !rd_req && !in_wr_req, "R1 outputs idle", 32'(ser_o), 0);

    // R2/R3 map, alias and outside access
    wr(12'h210, 32'h0000_1000);
    wr(12'h234, 32'h0000_8000);
    wr(12'h218, 32'd2);
    rd(12'h20E, 32'd128, "R5 load len*64");
    rd(12'h2EE, 32'd128, "R3 mirrored countdown");
    rd(12'h214, 32'h8000, "R3 mirrored base write");
    rd(12'h21C, 0, "R2 unmapped offset reads zero");
    wr(12'h110, 32'hDEAD_BEEF);
    wr(12'h310, 32'hDEAD_BEEF);
    rd(12'h210, 32'h1000, "R3 outside window ignored");
    rd(12'h110, 0, "R3 outside window reads zero");
    wr(12'h20E, 32'h1234);
    rd(12'h20E, 32'd128, "R2 countdown read-only");

    // R6 R7 R5: record + playback, fast rate, full ring twice
    wr(12'h200, 32'h0584);
    gap(DF, "R4 rate 10 spacing");
    idle(1200);

    // R9 + R4: alias write, rate 01, pass-through
    wr(12'h202, 32'h03C4);
    rd(12'h200, 32'h03C4, "R2 alias write updates ctrl");
    gap(DM, "R4 rate 01 spacing");
    idle(600);

    // R8 mute, rate 00
    wr(12'h200, 32'h0180);
    gap(DS, "R4 rate 00 spacing");
    begin
      bit any = 0;
      repeat (300) begin @(negedge clk); if (ser_o) any = 1; end
      chk(!any, "R8 muted output stays 0", 32'(any), 0);
    end

    // R4 rate 11 treated as 10, record only
    wr(12'h200, 32'h0680);
    gap(DF, "R4 rate 11 spacing");
    idle(300);

    // R10 stop and rewind
    wr(12'h200, 32'h0000);
    rd(12'h20E, 32'd128, "R10 stop rewinds countdown");
    begin
      int ticks = 0;
      repeat (100) begin @(negedge clk); if (bit_tick || rd_req) ticks++; end
      chk(ticks == 0, "R10 no activity when stopped", ticks, 0);
    end

    // R5 truncation, playback only
    wr(12'h218, 32'h0401);
    rd(12'h20E, 32'd64, "R5 count modulo 2^16");
    wr(12'h200, 32'h0504);
    idle(400);

    // R11 zero length keeps engine idle
    wr(12'h218, 32'h0000);
    begin
      int ticks = 0;
      repeat (50) begin @(negedge clk); if (bit_tick) ticks++; end
      chk(ticks == 0, "R11 zero countdown idle", ticks, 0);
    end
    rd(12'h20E, 0, "R11 countdown zero");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule